// File: doc/BRIEF.md
# Cycle-Counting IRQ Timer

This block is a 16-bit down-counter clocked by the CPU cycle clock that raises an interrupt once a programmed number of cycles has elapsed. Software loads the live count directly through a single write-twice address (high byte first, then low byte). A control address starts or pauses counting. A third address range acknowledges the interrupt. Nothing is reloaded automatically: on underflow the timer stops itself and waits for software.

While counting is enabled, an external interrupt input can also raise the interrupt. The interrupt output is active low and stays asserted until it is acknowledged.

Three small state machines make up the block:
- **Byte sequencer**, with states `SEQ_HI` and `SEQ_LO`. A load write moves `SEQ_HI` to `SEQ_LO` and `SEQ_LO` back to `SEQ_HI`. Any control write forces `SEQ_HI`.
- **Run controller**, with states `RUN_PAUSED` and `RUN_COUNTING`. A control write picks the state from data bit 4. Underflow moves `RUN_COUNTING` to `RUN_PAUSED`.
- **Interrupt latch**, with states `IRQ_CLEAR` and `IRQ_RAISED`. A set event moves `IRQ_CLEAR` to `IRQ_RAISED`. An acknowledge with no set event in the same cycle moves `IRQ_RAISED` to `IRQ_CLEAR`.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the interrupt output `irq_n` is high, the count is 0, counting is paused, and the next load write goes to the high byte. While paused, the external input has no effect.
- R2: Writes whose address ANDed with 0xF800 equals 0xC800 are load writes. They alternate between the two bytes of the live count: first bits 15:8, then bits 7:0, then the order repeats. A load write replaces the live count directly; there is no reload register.
- R3: Writes whose address ANDed with 0xF800 equals 0xD800 are control writes. Every control write returns the byte sequencer to the high byte. Data bit 4 of a control write selects counting (1) or paused (0).
- R4: While counting, the count decreases by 1 every cycle. In a cycle where the count is 0x0000 it wraps to 0xFFFF, the interrupt becomes pending, and counting pauses. Starting from count N, `irq_n` therefore falls after the (N+1)th counting cycle.
- R5: Any write whose address ANDed with 0x8800 equals 0x8000 clears a pending interrupt. Control writes do not clear it.
- R6: While counting is enabled, a high `ext_irq` sampled at a clock edge makes the interrupt pending.
- R7: If a load write and a decrement fall in the same cycle, the load wins. That cycle does not decrement and cannot wrap.
- R8: `irq_n` is low exactly while an interrupt is pending and stays low until acknowledged. If a set event and an acknowledge fall in the same cycle, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| ext_irq | input | 1 | External interrupt request, active high |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The timer is started from several loaded counts: a short count, a count built after the byte order was disturbed and then reset by a control write, and a count that is paused partway through and then resumed. Each run shows on which exact cycle `irq_n` falls, which separates a correct byte order and decrement rate from an off-by-one error or a swapped byte. Load writes landing on a counting cycle whose count is zero show whether loading wins over the wrap. External-input pulses are applied while paused, while counting, after self-pause, and together with an acknowledge, which separates gating by enable from ungated setting and shows the set-over-acknowledge priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {SEQ_HI, SEQ_LO} seq_e;
    typedef enum logic {RUN_PAUSED, RUN_COUNTING} run_e;
    typedef enum logic {IRQ_CLEAR, IRQ_RAISED} irq_e;

    typedef struct packed {
        logic ack;
        logic load;
        logic ctrl;
    } wr_sel_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] REG_MASK  = 16'hF800,
    parameter logic [15:0] LOAD_ADDR = 16'hC800,
    parameter logic [15:0] CTRL_ADDR = 16'hD800,
    parameter logic [15:0] ACK_MASK  = 16'h8800,
    parameter logic [15:0] ACK_ADDR  = 16'h8000
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output tmr_pkg::wr_sel_t  sel
);
    localparam logic [ADDR_W-1:0] M_REG = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] M_ACK = ADDR_W'(ACK_MASK);

    always_comb begin
        sel.load = we && ((addr & M_REG) == ADDR_W'(LOAD_ADDR));
        sel.ctrl = we && ((addr & M_REG) == ADDR_W'(CTRL_ADDR));
        sel.ack  = we && ((addr & M_ACK) == ADDR_W'(ACK_ADDR));
    end
endmodule

// File: rtl/tmr_byte_seq.sv
module tmr_byte_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic ctrl,
    output logic load_hi,
    output logic load_lo
);
    import tmr_pkg::*;

    seq_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_HI;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (ctrl) begin
            state_nx = SEQ_HI;
        end else if (load) begin
            unique case (state)
                SEQ_HI: state_nx = SEQ_LO;
                SEQ_LO: state_nx = SEQ_HI;
            endcase
        end
    end

    always_comb begin
        load_hi = load && (state == SEQ_HI);
        load_lo = load && (state == SEQ_LO);
    end

    assert_ctrl_rewinds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl |=> (state == SEQ_HI));
    assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !ctrl && state == SEQ_HI) |=> (state == SEQ_LO));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              ctrl,
    input  logic              ena_bit,
    input  logic [DATA_W-1:0] data,
    output logic              wrap,
    output logic              counting
);
    import tmr_pkg::*;

    run_e             state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             loading;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RUN_PAUSED;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        loading = load_hi || load_lo;
        wrap    = (state == RUN_COUNTING) && (cnt == '0) && !loading;
    end

    always_comb begin
        state_nx = state;
        if (ctrl) begin
            state_nx = ena_bit ? RUN_COUNTING : RUN_PAUSED;
        end else begin
            unique case (state)
                RUN_PAUSED:   state_nx = RUN_PAUSED;
                RUN_COUNTING: state_nx = wrap ? RUN_PAUSED : RUN_COUNTING;
            endcase
        end
    end

    always_comb begin
        cnt_nx = cnt;
        if (load_hi)
            cnt_nx = {data, cnt[CNT_W-DATA_W-1:0]};
        else if (load_lo)
            cnt_nx = {cnt[CNT_W-1:DATA_W], data};
        else if (state == RUN_COUNTING)
            cnt_nx = cnt - 1'b1;
    end

    always_comb counting = (state == RUN_COUNTING);

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !loading) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
    assert_wrap_pauses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctrl) |=> !counting);
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (cnt[DATA_W-1:0] == $past(data)));
    assert_enable_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl |=> (counting == $past(ena_bit)));
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic counting,
    input  logic ext_irq,
    input  logic ack,
    output logic irq_n
);
    import tmr_pkg::*;

    irq_e state, state_nx;
    logic set;

    always_comb set = wrap || (counting && ext_irq);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_CLEAR:  state_nx = set ? IRQ_RAISED : IRQ_CLEAR;
            IRQ_RAISED: state_nx = (ack && !set) ? IRQ_CLEAR : IRQ_RAISED;
        endcase
    end

    always_comb irq_n = (state != IRQ_RAISED);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> irq_n);
    assert_ext_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && ext_irq) |=> !irq_n);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack) |=> !irq_n);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int ENA_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              ext_irq,
    output logic              irq_n
);
    import tmr_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    wr_sel_t sel;
    logic    load_hi, load_lo, wrap, counting;

    tmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .we(cpu_we), .addr(cpu_addr), .sel(sel)
    );

    tmr_byte_seq u_seq (
        .clk(clk), .rst_n(rst_n), .load(sel.load), .ctrl(sel.ctrl),
        .load_hi(load_hi), .load_lo(load_lo)
    );

    tmr_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
        .ctrl(sel.ctrl), .ena_bit(cpu_data[ENA_BIT]), .data(cpu_data),
        .wrap(wrap), .counting(counting)
    );

    tmr_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .counting(counting),
        .ext_irq(ext_irq), .ack(sel.ack), .irq_n(irq_n)
    );

    assert_paused_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!counting && irq_n));
endmodule

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_we = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        ext_irq = 0;
    logic        irq_n;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    cyc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ext_irq(ext_irq), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic exp);
        total++;
        if (irq_n !== exp) begin
            bad++;
            $display("FAIL %s: irq_n actual=%b expected=%b at %0t", req, irq_n, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_we = 1; cpu_addr = a; cpu_data = d;
        @(posedge clk);
        @(negedge clk);
        cpu_we = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset", 1'b1);
        ext_irq = 1; cyc(3); ext_irq = 0;
        check("R1 paused after reset ignores ext", 1'b1);
    endtask

    task automatic t_basic;
        wr(16'hC800, 8'h00); wr(16'hC800, 8'h03); wr(16'hD800, 8'h10);
        cyc(3); check("R4 before wrap", 1'b1);
        cyc(1); check("R4 wrap raises", 1'b0);
        wr(16'hD800, 8'h00); check("R5 ctrl does not ack", 1'b0);
        cyc(5); check("R8 held until ack", 1'b0);
        wr(16'h8000, 8'h00); check("R5 ack clears", 1'b1);
        ext_irq = 1; cyc(2); ext_irq = 0;
        check("R4 self-paused after wrap", 1'b1);
    endtask

    task automatic t_toggle;
        wr(16'hC800, 8'h12); wr(16'hD800, 8'h00);
        wr(16'hCFFF, 8'h00); wr(16'hC800, 8'h05); wr(16'hD800, 8'h10);
        cyc(5); check("R2 R3 toggle reset count 5 early", 1'b1);
        cyc(1); check("R2 R3 toggle reset count 5 wrap", 1'b0);
        wr(16'h8123, 8'h00); check("R5 ack mirror", 1'b1);
    endtask

    task automatic t_enable_bit;
        wr(16'hC800, 8'h00); wr(16'hC800, 8'h01); wr(16'hD800, 8'hEF);
        cyc(10); check("R3 bit4 clear keeps paused", 1'b1);
        ext_irq = 1; cyc(1); ext_irq = 0;
        check("R6 ext ignored while paused", 1'b1);
    endtask

    task automatic t_pause_resume;
        wr(16'hD800, 8'h00); wr(16'hC800, 8'h00); wr(16'hC800, 8'h05);
        wr(16'hD800, 8'h10); wr(16'hD800, 8'h00);
        cyc(20); check("R3 R4 paused mid count", 1'b1);
        wr(16'hD800, 8'h10);
        cyc(4); check("R4 resume remaining 4", 1'b1);
        cyc(1); check("R4 resume wrap", 1'b0);
        wr(16'h8000, 8'h00); check("R5 ack", 1'b1);
    endtask

    task automatic t_priority;
        wr(16'hD800, 8'h00); wr(16'hC800, 8'h01); wr(16'hC800, 8'h00);
        wr(16'hD800, 8'h10); wr(16'hC800, 8'h00); wr(16'hC800, 8'h03);
        check("R7 load beats wrap at zero", 1'b1);
        cyc(3); check("R7 count 3 early", 1'b1);
        cyc(1); check("R7 count 3 wrap", 1'b0);
        wr(16'h8000, 8'h00); check("R5 ack", 1'b1);
    endtask

    task automatic t_ext;
        wr(16'hD800, 8'h00); wr(16'hC800, 8'hFF); wr(16'hC800, 8'hFF);
        wr(16'hD800, 8'h10);
        check("R6 no irq before ext", 1'b1);
        ext_irq = 1; cyc(1); ext_irq = 0;
        check("R6 ext raises while counting", 1'b0);
        ext_irq = 1; wr(16'h8000, 8'h00); ext_irq = 0;
        check("R8 set beats ack", 1'b0);
        wr(16'h8000, 8'h00); check("R8 ack alone clears", 1'b1);
        wr(16'hD800, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        t_reset();
        t_basic();
        t_toggle();
        t_enable_bit();
        t_pause_resume();
        t_priority();
        t_ext();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule